// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core and handles the moment the core leaves normal execution for an event handler. When the core raises `eval`, the block checks the pending exception and the pending hardware interrupt and decides which one, if either, is taken. It then changes the architectural state in one cycle. The changes are:

- the new program counter,
- the status register with its block, privileged and bank bits set,
- the saved program counter, saved status and saved stack pointer,
- the exception or interrupt event code register,
- the cleared delay-slot flags.

The core shows its live values on the input ports. The block takes a copy of them when it accepts `eval`. It drives the register copies on its outputs and raises `entry_pulse` for one cycle when they change.

The sequencer has three states. In `S_IDLE` it waits. If `eval` arrives with a takeable event, the **accept** transition copies the inputs and goes to `S_COMMIT`. If `eval` arrives with nothing takeable, the **decline** transition stays in `S_IDLE`. In `S_COMMIT` every output register is written, and the **commit** transition goes to `S_DONE`. `S_DONE` is a single guard cycle in which `entry_pulse` is high and `eval` is ignored. The **release** transition then returns to `S_IDLE`.

The interrupt controller reads the current mask level from `irq_mask_level`. It answers with a vector and a valid flag on the same cycle. That priority logic belongs to the controller, not to this block.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_pend` and an interrupt (`irq_req` with `irq_vec_valid`) are both present at `eval`, the exception is taken and `intevt_out` is left unchanged.
- R2: With the block bit (SR bit 28) set, every exception code other than 0x1E0 is taken as code 0x000. `expevt_out` becomes 0x000 and the reset target is used. Code 0x1E0 is taken unchanged as a general exception.
- R3: With the block bit set, an interrupt with no pending exception is ignored. No `entry_pulse` follows, and all outputs keep their values.
- R4: `irq_mask_level` always equals `sr_in[7:4]`. An interrupt is taken only if `irq_vec_valid` is high. Otherwise nothing is taken.
- R5: On every entry, `sgr_out` receives `r15_in` and `ssr_out` receives `sr_in`. `sr_out` is `sr_in` with bit 28 (block), bit 29 (bank) and bit 30 (privileged) set.
- R6: Reset-class codes are 0x000 and 0x020. For them, `sr_out[7:4]` becomes 0xF and `pc_out` becomes 0xA0000000, regardless of `vbr_in`.
- R7: TLB-miss codes 0x040 and 0x060 branch to `vbr_in` + 0x400. Every other exception code that is not reset-class branches to `vbr_in` + 0x100.
- R8: A taken interrupt branches to `vbr_in` + 0x600 and writes `irq_vec` into `intevt_out`, leaving `expevt_out` unchanged. A taken exception writes its effective code into `expevt_out`.
- R9: `spc_out` is `pc_in`. It is reduced by 2 when `flags_in[0]` (delay slot) or `flags_in[1]` (conditional delay slot) is set. It is increased by 2 when the effective code is 0x160 (trap).
- R10: `flags_out` follows `flags_in` one cycle late, except that the commit cycle writes it to zero.
- R11: If `eval` is sampled in `S_IDLE` at edge k, all outputs change at edge k+1 and `entry_pulse` is high from edge k+1 to edge k+2 only. `eval` sampled at edge k+1 or k+2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval | input | 1 | Request to evaluate pending events |
| exc_pend | input | 1 | An exception code is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Hardware interrupt request |
| irq_mask_level | output | 4 | Current mask level sent to the interrupt controller |
| irq_vec_valid | input | 1 | Controller has a vector above the mask level |
| irq_vec | input | 12 | Controller's interrupt vector |
| sr_in | input | 32 | Live status register |
| pc_in | input | 32 | Program counter of the faulting instruction |
| r15_in | input | 32 | Live stack register |
| vbr_in | input | 32 | Vector base register |
| flags_in | input | 3 | Delay-slot flags: bit 0 slot, bit 1 conditional slot, bit 2 slot-taken |
| pc_out | output | 32 | Handler entry address |
| sr_out | output | 32 | Status register after entry |
| spc_out | output | 32 | Saved program counter |
| ssr_out | output | 32 | Saved status register |
| sgr_out | output | 32 | Saved stack pointer |
| expevt_out | output | 12 | Exception event code register |
| intevt_out | output | 12 | Interrupt event code register |
| flags_out | output | 3 | Delay-slot flags as seen after entry |
| entry_pulse | output | 1 | One-cycle marker of a completed entry |

## Verification
The assertions assume that `eval` is only a request and may come at any time. They assume nothing about how `exc_pend`, `irq_req` and the vector relate. They do assume that reset is held for at least one edge before the first `eval`. The stimulus draws status words with the block bit, exception codes from the reset, TLB-miss, trap, exempt and general groups, and random delay-slot flags. It holds each request's inputs steady until the commit edge has passed, and it places one deliberate `eval` inside the guard cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int EV_CODE_W   = 12;
    localparam int SR_BLK_BIT  = 28;
    localparam int SR_BANK_BIT = 29;
    localparam int SR_PRIV_BIT = 30;
    localparam int IMASK_LO    = 4;
    localparam int IMASK_W     = 4;
    localparam int SLOT_BIT    = 0;
    localparam int CSLOT_BIT   = 1;

    localparam logic [EV_CODE_W-1:0] CODE_POWER  = 12'h000;
    localparam logic [EV_CODE_W-1:0] CODE_MANUAL = 12'h020;
    localparam logic [EV_CODE_W-1:0] CODE_TLB_RD = 12'h040;
    localparam logic [EV_CODE_W-1:0] CODE_TLB_WR = 12'h060;
    localparam logic [EV_CODE_W-1:0] CODE_TRAP   = 12'h160;
    localparam logic [EV_CODE_W-1:0] CODE_EXEMPT = 12'h1E0;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_RESET,
        EV_TLBMISS,
        EV_TRAP,
        EV_GENERAL,
        EV_IRQ
    } ev_class_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COMMIT,
        S_DONE
    } seq_state_e;

    function automatic ev_class_e classify_exc(input logic [EV_CODE_W-1:0] code);
        ev_class_e c;
        unique case (code)
            CODE_POWER, CODE_MANUAL:   c = EV_RESET;
            CODE_TLB_RD, CODE_TLB_WR:  c = EV_TLBMISS;
            CODE_TRAP:                 c = EV_TRAP;
            default:                   c = EV_GENERAL;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
    import exc_entry_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_pend,
    input  logic [EV_CODE_W-1:0] exc_code,
    input  logic                 irq_req,
    input  logic                 irq_vec_valid,
    input  logic [EV_CODE_W-1:0] irq_vec,
    input  logic                 blk,
    output logic                 take,
    output ev_class_e            ev_class,
    output logic [EV_CODE_W-1:0] ev_code
);

    logic [EV_CODE_W-1:0] eff_code;
    logic                 irq_ok;

    always_comb begin
        eff_code = exc_code;
        if (blk && (exc_code != CODE_EXEMPT)) begin
            eff_code = CODE_POWER;
        end
    end

    assign irq_ok = irq_req && !blk && irq_vec_valid;

    always_comb begin
        take     = 1'b0;
        ev_class = EV_NONE;
        ev_code  = '0;
        if (exc_pend) begin
            take     = 1'b1;
            ev_class = classify_exc(eff_code);
            ev_code  = eff_code;
        end else if (irq_ok) begin
            take     = 1'b1;
            ev_class = EV_IRQ;
            ev_code  = irq_vec;
        end
    end

    AST_EXC_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend |-> (ev_class != EV_IRQ)); // R1

    AST_BLOCK_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        blk |-> (ev_class != EV_IRQ)); // R3

    AST_BLOCK_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_pend && blk && exc_code != CODE_EXEMPT) |-> (ev_class == EV_RESET)); // R2

endmodule

// File: rtl/exc_entry_target.sv
module exc_entry_target
    import exc_entry_pkg::*;
#(
    parameter int                 DATA_W     = 32,
    parameter int                 FLAG_W     = 3,
    parameter int                 INSN_BYTES = 2,
    parameter logic [DATA_W-1:0]  RESET_PC   = 32'hA000_0000,
    parameter logic [DATA_W-1:0]  TLB_OFS    = 32'h0000_0400,
    parameter logic [DATA_W-1:0]  GEN_OFS    = 32'h0000_0100,
    parameter logic [DATA_W-1:0]  IRQ_OFS    = 32'h0000_0600
) (
    input  ev_class_e          ev_class,
    input  logic [DATA_W-1:0]  sr,
    input  logic [DATA_W-1:0]  pc,
    input  logic [DATA_W-1:0]  vbr,
    input  logic [FLAG_W-1:0]  flags,
    output logic [DATA_W-1:0]  new_pc,
    output logic [DATA_W-1:0]  new_sr,
    output logic [DATA_W-1:0]  saved_pc
);

    localparam logic [DATA_W-1:0] ENTRY_SET =
        (DATA_W'(1) << SR_BLK_BIT) | (DATA_W'(1) << SR_BANK_BIT) | (DATA_W'(1) << SR_PRIV_BIT);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

    logic in_slot;

    assign in_slot = flags[SLOT_BIT] | flags[CSLOT_BIT];

    always_comb begin
        new_sr   = sr | ENTRY_SET;
        new_pc   = vbr + GEN_OFS;
        saved_pc = in_slot ? (pc - STEP) : pc;
        unique case (ev_class)
            EV_RESET: begin
                new_sr[IMASK_LO +: IMASK_W] = '1;
                new_pc = RESET_PC;
            end
            EV_TLBMISS: new_pc = vbr + TLB_OFS;
            EV_TRAP:    saved_pc = saved_pc + STEP;
            EV_IRQ:     new_pc = vbr + IRQ_OFS;
            default:    ;
        endcase
    end

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic take,
    output logic snap_en,
    output logic commit,
    output logic entry_pulse
);

    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (eval && take) state_nx = S_COMMIT;
            S_COMMIT: state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        snap_en = 1'b0;
        commit  = 1'b0;
        unique case (state)
            S_IDLE:   snap_en = eval && take;
            S_COMMIT: commit  = 1'b1;
            S_DONE:   ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) entry_pulse <= 1'b0;
        else        entry_pulse <= commit;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |=> !entry_pulse); // R11

    AST_COMMIT_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |=> (state == S_DONE && entry_pulse)); // R11

    AST_GUARD_IGNORES_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> (state == S_IDLE)); // R11

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int                 DATA_W     = 32,
    parameter int                 FLAG_W     = 3,
    parameter int                 INSN_BYTES = 2,
    parameter logic [DATA_W-1:0]  RESET_PC   = 32'hA000_0000,
    parameter logic [DATA_W-1:0]  TLB_OFS    = 32'h0000_0400,
    parameter logic [DATA_W-1:0]  GEN_OFS    = 32'h0000_0100,
    parameter logic [DATA_W-1:0]  IRQ_OFS    = 32'h0000_0600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval,
    input  logic                 exc_pend,
    input  logic [EV_CODE_W-1:0] exc_code,
    input  logic                 irq_req,
    output logic [IMASK_W-1:0]   irq_mask_level,
    input  logic                 irq_vec_valid,
    input  logic [EV_CODE_W-1:0] irq_vec,
    input  logic [DATA_W-1:0]    sr_in,
    input  logic [DATA_W-1:0]    pc_in,
    input  logic [DATA_W-1:0]    r15_in,
    input  logic [DATA_W-1:0]    vbr_in,
    input  logic [FLAG_W-1:0]    flags_in,
    output logic [DATA_W-1:0]    pc_out,
    output logic [DATA_W-1:0]    sr_out,
    output logic [DATA_W-1:0]    spc_out,
    output logic [DATA_W-1:0]    ssr_out,
    output logic [DATA_W-1:0]    sgr_out,
    output logic [EV_CODE_W-1:0] expevt_out,
    output logic [EV_CODE_W-1:0] intevt_out,
    output logic [FLAG_W-1:0]    flags_out,
    output logic                 entry_pulse
);

    logic                 take;
    ev_class_e            arb_class;
    logic [EV_CODE_W-1:0] arb_code;
    logic                 snap_en;
    logic                 commit;

    ev_class_e            snap_class;
    logic [EV_CODE_W-1:0] snap_code;
    logic [DATA_W-1:0]    snap_sr;
    logic [DATA_W-1:0]    snap_pc;
    logic [DATA_W-1:0]    snap_r15;
    logic [DATA_W-1:0]    snap_vbr;
    logic [FLAG_W-1:0]    snap_flags;

    logic [DATA_W-1:0]    tgt_pc;
    logic [DATA_W-1:0]    tgt_sr;
    logic [DATA_W-1:0]    tgt_spc;

    assign irq_mask_level = sr_in[IMASK_LO +: IMASK_W];

    exc_entry_arbiter u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_pend      (exc_pend),
        .exc_code      (exc_code),
        .irq_req       (irq_req),
        .irq_vec_valid (irq_vec_valid),
        .irq_vec       (irq_vec),
        .blk           (sr_in[SR_BLK_BIT]),
        .take          (take),
        .ev_class      (arb_class),
        .ev_code       (arb_code)
    );

    exc_entry_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval        (eval),
        .take        (take),
        .snap_en     (snap_en),
        .commit      (commit),
        .entry_pulse (entry_pulse)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_class <= EV_NONE;
            snap_code  <= '0;
            snap_sr    <= '0;
            snap_pc    <= '0;
            snap_r15   <= '0;
            snap_vbr   <= '0;
            snap_flags <= '0;
        end else if (snap_en) begin
            snap_class <= arb_class;
            snap_code  <= arb_code;
            snap_sr    <= sr_in;
            snap_pc    <= pc_in;
            snap_r15   <= r15_in;
            snap_vbr   <= vbr_in;
            snap_flags <= flags_in;
        end
    end

    exc_entry_target #(
        .DATA_W     (DATA_W),
        .FLAG_W     (FLAG_W),
        .INSN_BYTES (INSN_BYTES),
        .RESET_PC   (RESET_PC),
        .TLB_OFS    (TLB_OFS),
        .GEN_OFS    (GEN_OFS),
        .IRQ_OFS    (IRQ_OFS)
    ) u_tgt (
        .ev_class (snap_class),
        .sr       (snap_sr),
        .pc       (snap_pc),
        .vbr      (snap_vbr),
        .flags    (snap_flags),
        .new_pc   (tgt_pc),
        .new_sr   (tgt_sr),
        .saved_pc (tgt_spc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out     <= '0;
            sr_out     <= '0;
            spc_out    <= '0;
            ssr_out    <= '0;
            sgr_out    <= '0;
            expevt_out <= '0;
            intevt_out <= '0;
        end else if (commit) begin
            pc_out  <= tgt_pc;
            sr_out  <= tgt_sr;
            spc_out <= tgt_spc;
            ssr_out <= snap_sr;
            sgr_out <= snap_r15;
            if (snap_class == EV_IRQ) intevt_out <= snap_code;
            else                      expevt_out <= snap_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      flags_out <= '0;
        else if (commit) flags_out <= '0;
        else             flags_out <= flags_in;
    end

    AST_ENTRY_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (sr_out[SR_BLK_BIT] && sr_out[SR_BANK_BIT] && sr_out[SR_PRIV_BIT])); // R5

    AST_RESET_IMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_pulse && pc_out == RESET_PC && expevt_out == CODE_POWER && $changed(expevt_out))
            |-> (sr_out[IMASK_LO +: IMASK_W] == '1)); // R6

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> (flags_out == '0)); // R10

    AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_level == sr_in[IMASK_LO +: IMASK_W]); // R4

endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval = 1'b0;
    logic        exc_pend = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_mask_level;
    logic        irq_vec_valid = 1'b0;
    logic [11:0] irq_vec = '0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic [2:0]  flags_in = '0;
    logic [31:0] pc_out, sr_out, spc_out, ssr_out, sgr_out;
    logic [11:0] expevt_out, intevt_out;
    logic [2:0]  flags_out;
    logic        entry_pulse;

    int checks = 0;
    int errors = 0;

    logic [31:0] e_pc = '0, e_sr = '0, e_spc = '0, e_ssr = '0, e_sgr = '0;
    logic [11:0] e_exp = '0, e_int = '0;
    logic        e_take;

    localparam logic [31:0] BLK = 32'h1000_0000;

    always #2 clk = ~clk;

    exc_entry_seq uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic xp, input logic [11:0] xc, input logic iq, input logic vv,
                         input logic [11:0] vec, input logic [31:0] sr, input logic [31:0] pc,
                         input logic [31:0] r15, input logic [31:0] vbr, input logic [2:0] fl);
        logic blk;
        logic [11:0] code;
        logic [31:0] spc;
        blk  = sr[28];
        code = (blk && xc != 12'h1E0) ? 12'h000 : xc;
        e_take = xp || (iq && !blk && vv);
        if (e_take) begin
            e_sgr = r15;
            e_ssr = sr;
            e_sr  = sr | 32'h7000_0000;
            spc   = (fl[0] || fl[1]) ? pc - 32'd2 : pc;
            if (xp) begin
                e_exp = code;
                if (code == 12'h000 || code == 12'h020) begin
                    e_pc = 32'hA000_0000;
                    e_sr[7:4] = 4'hF;
                end else if (code == 12'h040 || code == 12'h060) begin
                    e_pc = vbr + 32'h400;
                end else begin
                    e_pc = vbr + 32'h100;
                end
                if (code == 12'h160) spc = spc + 32'd2;
            end else begin
                e_int = vec;
                e_pc  = vbr + 32'h600;
            end
            e_spc = spc;
        end
    endtask

    task automatic check_all(input string tag);
        chk(pc_out == e_pc, {tag, " R6/R7/R8 pc"}, pc_out, e_pc);
        chk(sr_out == e_sr, {tag, " R5/R6 sr"}, sr_out, e_sr);
        chk(spc_out == e_spc, {tag, " R9 spc"}, spc_out, e_spc);
        chk(ssr_out == e_ssr && sgr_out == e_sgr, {tag, " R5 ssr/sgr"}, sgr_out, e_sgr);
        chk(expevt_out == e_exp, {tag, " R2/R8 expevt"}, {20'd0, expevt_out}, {20'd0, e_exp});
        chk(intevt_out == e_int, {tag, " R1/R8 intevt"}, {20'd0, intevt_out}, {20'd0, e_int});
    endtask

    task automatic do_event(input string tag, input logic xp, input logic [11:0] xc, input logic iq,
                            input logic vv, input logic [11:0] vec, input logic [31:0] sr,
                            input logic [31:0] pc, input logic [31:0] r15, input logic [31:0] vbr,
                            input logic [2:0] fl);
        exc_pend = xp; exc_code = xc; irq_req = iq; irq_vec_valid = vv; irq_vec = vec;
        sr_in = sr; pc_in = pc; r15_in = r15; vbr_in = vbr; flags_in = fl;
        eval = 1'b1;
        model(xp, xc, iq, vv, vec, sr, pc, r15, vbr, fl);
        @(posedge clk); @(negedge clk);
        eval = 1'b0;
        chk(irq_mask_level == sr[7:4], {tag, " R4 mask level"}, {28'd0, irq_mask_level}, {28'd0, sr[7:4]});
        @(posedge clk); @(negedge clk);
        chk(entry_pulse == e_take, {tag, " R11/R3/R4 pulse"}, {31'd0, entry_pulse}, {31'd0, e_take});
        chk(flags_out == (e_take ? 3'd0 : fl), {tag, " R10 flags"}, {29'd0, flags_out}, {29'd0, e_take ? 3'd0 : fl});
        check_all(tag);
        @(posedge clk); @(negedge clk);
        chk(entry_pulse == 1'b0, {tag, " R11 pulse end"}, {31'd0, entry_pulse}, 32'd0);
        chk(flags_out == fl, {tag, " R10 follow"}, {29'd0, flags_out}, {29'd0, fl});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5813));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(entry_pulse == 1'b0 && pc_out == 32'd0 && sr_out == 32'd0, "reset R11", pc_out, 32'd0);
        chk(expevt_out == 12'd0 && intevt_out == 12'd0 && flags_out == 3'd0, "reset R8", {20'd0, expevt_out}, 32'd0);

        do_event("gen slot", 1, 12'h180, 0, 0, 12'h0, 32'h0000_0030, 32'h0C00_1000, 32'h8C00_FF00, 32'h8000_0000, 3'b001);
        do_event("tlb miss R7", 1, 12'h040, 0, 0, 12'h0, 32'h0000_00A0, 32'h0040_2000, 32'h1111_2222, 32'h8100_0000, 3'b000);
        do_event("tlb write R7", 1, 12'h060, 0, 0, 12'h0, 32'h0000_0000, 32'h0040_2008, 32'h1111_2226, 32'h8100_0000, 3'b100);
        do_event("trap R9", 1, 12'h160, 0, 0, 12'h0, 32'h4000_0000, 32'h0000_3000, 32'h0000_7000, 32'h8800_0000, 3'b000);
        do_event("exc vs irq R1", 1, 12'h0A0, 1, 1, 12'h600, 32'h0000_0020, 32'h0000_4000, 32'h0000_5000, 32'h8000_1000, 3'b010);
        do_event("irq R8", 0, 12'h0, 1, 1, 12'h320, 32'h0000_0050, 32'h0000_6000, 32'h0000_5500, 32'h8000_1000, 3'b000);
        do_event("blk reset R2", 1, 12'h0A0, 0, 0, 12'h0, BLK | 32'h10, 32'h0000_7000, 32'h0000_1234, 32'h8000_2000, 3'b000);
        do_event("blk exempt R2", 1, 12'h1E0, 0, 0, 12'h0, BLK, 32'h0000_7100, 32'h0000_1238, 32'h8000_2000, 3'b000);
        do_event("blk irq R3", 0, 12'h0, 1, 1, 12'h3C0, BLK | 32'h40, 32'h0000_7200, 32'h0000_123C, 32'h8000_2000, 3'b001);
        do_event("no vector R4", 0, 12'h0, 1, 0, 12'h3C0, 32'h0000_00F0, 32'h0000_7300, 32'h0000_1240, 32'h8000_2000, 3'b000);
        do_event("manual reset R6", 1, 12'h020, 0, 0, 12'h0, 32'h0000_0000, 32'h0000_7400, 32'h0000_1244, 32'h9000_0000, 3'b011);

        // R11: an eval that lands in the guard cycle is ignored
        exc_pend = 1; exc_code = 12'h180; irq_req = 0; irq_vec_valid = 0;
        sr_in = 32'h0; pc_in = 32'h0000_9000; r15_in = 32'h0000_9100; vbr_in = 32'h8200_0000; flags_in = 3'b000;
        model(1, 12'h180, 0, 0, 12'h0, 32'h0, 32'h0000_9000, 32'h0000_9100, 32'h8200_0000, 3'b000);
        eval = 1;
        @(posedge clk); @(negedge clk);
        eval = 0;
        @(posedge clk); @(negedge clk);
        exc_code = 12'h040; eval = 1;
        @(posedge clk); @(negedge clk);
        eval = 0;
        @(posedge clk); @(negedge clk);
        chk(entry_pulse == 1'b0, "guard R11 pulse", {31'd0, entry_pulse}, 32'd0);
        check_all("guard R11");

        for (int i = 0; i < 300; i++) begin
            logic [11:0] codes [8];
            logic [31:0] sr;
            codes = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h0A0, 12'h160, 12'h1E0, 12'h180};
            sr = $urandom & 32'h1FFF_FFFF;
            if ($urandom_range(3) == 0) sr = sr | BLK;
            else sr = sr & ~BLK;
            do_event("random", 1'($urandom_range(1)), codes[$urandom_range(7)], 1'($urandom_range(1)),
                     1'($urandom_range(1)), 12'($urandom) & 12'hFE0, sr, $urandom & 32'hFFFF_FFFE,
                     $urandom, $urandom & 32'hFFFF_F000, 3'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule